// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This block searches a device's configuration-space capability chain for one capability ID. A requester presents a target ID. The walker then fetches bytes one at a time through a narrow read port that uses a request/valid handshake. It first confirms that the device advertises a capability chain at all. It then follows the chain node by node until one of three things happens: it meets the target, it meets a terminator, or it runs out of its hop budget.

The result is a found flag and, when found, the dword-aligned offset of the matching node. The walker defends itself against bad chains in three ways. It masks the low pointer bits. It treats any pointer that lands inside the fixed header region as the end of the chain. It bounds the number of nodes it visits, so a chain that loops back on itself cannot hang it.

Top module: `cap_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done` and `rd_req` are low.
- R2: A request (`req_valid` high while `busy` is low) is accepted on a clock edge, and `busy` is high from the next cycle until the walk ends. A `req_valid` pulse while `busy` is high is ignored and starts no further walk.
- R3: The first read of every walk is the byte at offset 0x06, which is the low byte of the status word. If bit 4 of that byte is 0, the walk ends not-found after exactly one read.
- R4: If the capability bit is set, the second read is the chain-head pointer byte at offset 0x34.
- R5: Every pointer has its two low bits cleared. The ID byte is read at the cleared address, and on a match `cap_ofs` reports that cleared address.
- R6: A cleared pointer below 0x40 ends the walk not-found, with no read at that pointer.
- R7: An ID byte of 0xFF ends the walk not-found. This takes precedence over a target of 0xFF.
- R8: When an ID does not match, the next pointer is read from the ID address plus one.
- R9: No more than 48 ID bytes are read in one walk. If the 48th ID does not match, the walk ends not-found after reading that node's next pointer.
- R10: Only one read is in flight at a time: `rd_req` stays high with a stable `rd_addr` until a cycle with `rd_valid` high, and `rd_req` is high only while `busy` is high.
- R11: `done` is a one-cycle pulse in the cycle after `busy` falls. `found` and `cap_ofs` are updated only at that moment, and `cap_ofs` is 0 when the result is not-found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a search (taken when not busy) |
| req_id | input | 8 | Capability ID to look for |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | Target located |
| cap_ofs | output | 8 | Aligned offset of the match, 0 if none |
| rd_req | output | 1 | Config byte read request |
| rd_addr | output | 8 | Config byte address |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 8 | Returned config byte |

## Verification
The bench aims at these failure modes:
- A head pointer with stray low bits. A design that does not mask them reports an unaligned offset or misses the node.
- A head pointer just under the header limit. A design that tests the raw value, or skips the test, would fetch from inside the header.
- A chain whose first node points back to itself. Without the hop cap this hangs; with an off-by-one cap the read count differs from 98.
- A 48-node chain whose target sits on the last node. A cap that is one too tight loses the match.

It also checks that a terminator ID stops the walk and that a cleared status bit stops it after one read. Read latency is varied so that a design which drops its request early, or acts on a stale byte, reaches a different node.

// File: rtl/cap_walker_pkg.sv
package cap_walker_pkg;

   typedef enum logic [2:0] {
      CW_IDLE    = 3'd0,
      CW_RD_STS  = 3'd1,
      CW_RD_HEAD = 3'd2,
      CW_EVAL    = 3'd3,
      CW_RD_ID   = 3'd4,
      CW_RD_LINK = 3'd5
   } cw_state_e;

   typedef struct packed {
      logic       hit;
      logic [7:0] ofs;
   } cw_result_t;

endpackage

// File: rtl/cap_walker_rdport.sv
module cap_walker_rdport #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [AW-1:0] issue_addr,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);
   logic          req_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         if (issue) begin
            req_q  <= 1'b1;
            addr_q <= issue_addr;
         end else if (rd_valid) begin
            req_q  <= 1'b0;
         end
      end
   end

   assign rd_req    = req_q;
   assign rd_addr   = addr_q;
   assign rsp_valid = req_q & rd_valid;
   assign rsp_data  = rd_data;

   // R10: a pending request is held with its address until answered
   a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

endmodule

// File: rtl/cap_walker_hopctr.sv
module cap_walker_hopctr #(
   parameter int MAX_HOPS = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic limit
);
   localparam int CW = $clog2(MAX_HOPS + 1);
   localparam logic [CW-1:0] LIM = CW'(MAX_HOPS);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + CW'(1);
   end

   assign limit = (cnt == LIM);

   // R9: the visit counter never passes the budget
   a_r9_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);

   // R9: no visit is started once the budget is spent
   a_r9_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      limit |-> !inc);

endmodule

// File: rtl/cap_walker_ptrchk.sv
module cap_walker_ptrchk #(
   parameter int AW         = 8,
   parameter int ALIGN_BITS = 2,
   parameter int MIN_PTR    = 'h40
) (
   input  logic [AW-1:0] raw,
   output logic [AW-1:0] aligned,
   output logic          below
);
   localparam logic [AW-1:0] FLOOR = AW'(MIN_PTR);

   generate
      if (ALIGN_BITS == 0) begin : g_noalign
         assign aligned = raw;
      end else begin : g_align
         assign aligned = {raw[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   endgenerate

   assign below = (aligned < FLOOR);

endmodule

// File: rtl/cap_walker.sv
module cap_walker
   import cap_walker_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int STS_OFS     = 'h06,
   parameter int STS_BIT     = 4,
   parameter int HEAD_OFS    = 'h34,
   parameter int MIN_PTR     = 'h40,
   parameter int ALIGN_BITS  = 2,
   parameter int MAX_HOPS    = 48,
   parameter int END_ID      = 'hFF,
   parameter int LINK_DELTA  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [DW-1:0] req_id,
   output logic          busy,
   output logic          done,
   output logic          found,
   output logic [AW-1:0] cap_ofs,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data
);
   localparam logic [AW-1:0] A_STS  = AW'(STS_OFS);
   localparam logic [AW-1:0] A_HEAD = AW'(HEAD_OFS);
   localparam logic [DW-1:0] ID_END = DW'(END_ID);
   localparam logic [AW-1:0] DELTA  = AW'(LINK_DELTA);
   localparam logic [AW-1:0] FLOOR  = AW'(MIN_PTR);

   generate
      if (STS_BIT >= DW) begin : g_bad_bit
         $error("cap_walker: STS_BIT outside the data byte");
      end
      if (ALIGN_BITS >= AW) begin : g_bad_align
         $error("cap_walker: ALIGN_BITS too wide");
      end
      if (MIN_PTR >= (1 << AW)) begin : g_bad_floor
         $error("cap_walker: MIN_PTR not addressable");
      end
      if (MAX_HOPS < 1) begin : g_bad_hops
         $error("cap_walker: MAX_HOPS must be positive");
      end
   endgenerate

   cw_state_e     st, st_nxt;
   logic [DW-1:0] tgt_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] node_q;
   cw_result_t    res_q, res_nxt;
   logic          done_q;

   logic          issue;
   logic [AW-1:0] issue_addr;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          hop_clr, hop_inc, hop_limit;
   logic [AW-1:0] ptr_aligned;
   logic          ptr_below;
   logic          ptr_load, node_load, fin;

   cap_walker_rdport #(.AW(AW), .DW(DW)) u_rdport (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_addr (issue_addr),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   cap_walker_hopctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hop_clr),
      .inc   (hop_inc),
      .limit (hop_limit)
   );

   cap_walker_ptrchk #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .MIN_PTR(MIN_PTR)) u_ptr (
      .raw     (ptr_q),
      .aligned (ptr_aligned),
      .below   (ptr_below)
   );

   always_comb begin
      st_nxt     = st;
      issue      = 1'b0;
      issue_addr = '0;
      hop_clr    = 1'b0;
      hop_inc    = 1'b0;
      ptr_load   = 1'b0;
      node_load  = 1'b0;
      fin        = 1'b0;
      res_nxt    = '0;
      unique case (st)
         CW_IDLE: begin
            if (req_valid) begin
               issue      = 1'b1;
               issue_addr = A_STS;
               hop_clr    = 1'b1;
               st_nxt     = CW_RD_STS;
            end
         end
         CW_RD_STS: begin
            if (rsp_valid) begin
               if (rsp_data[STS_BIT]) begin
                  issue      = 1'b1;
                  issue_addr = A_HEAD;
                  st_nxt     = CW_RD_HEAD;
               end else begin
                  fin    = 1'b1;
                  st_nxt = CW_IDLE;
               end
            end
         end
         CW_RD_HEAD, CW_RD_LINK: begin
            if (rsp_valid) begin
               ptr_load = 1'b1;
               st_nxt   = CW_EVAL;
            end
         end
         CW_EVAL: begin
            if (ptr_below || hop_limit) begin
               fin    = 1'b1;
               st_nxt = CW_IDLE;
            end else begin
               issue      = 1'b1;
               issue_addr = ptr_aligned;
               hop_inc    = 1'b1;
               node_load  = 1'b1;
               st_nxt     = CW_RD_ID;
            end
         end
         CW_RD_ID: begin
            if (rsp_valid) begin
               if (rsp_data == ID_END) begin
                  fin    = 1'b1;
                  st_nxt = CW_IDLE;
               end else if (rsp_data == tgt_q) begin
                  fin         = 1'b1;
                  res_nxt.hit = 1'b1;
                  res_nxt.ofs = node_q;
                  st_nxt      = CW_IDLE;
               end else begin
                  issue      = 1'b1;
                  issue_addr = node_q + DELTA;
                  st_nxt     = CW_RD_LINK;
               end
            end
         end
         default: st_nxt = CW_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CW_IDLE;
         tgt_q  <= '0;
         ptr_q  <= '0;
         node_q <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st     <= st_nxt;
         done_q <= fin;
         if (st == CW_IDLE && req_valid) tgt_q  <= req_id;
         if (ptr_load)                   ptr_q  <= rsp_data[AW-1:0];
         if (node_load)                  node_q <= ptr_aligned;
         if (fin)                        res_q  <= res_nxt;
      end
   end

   assign busy    = (st != CW_IDLE);
   assign done    = done_q;
   assign found   = res_q.hit;
   assign cap_ofs = res_q.ofs;

   // R2: an accepted request raises busy on the next cycle
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   // R11: the walk ends with a result strobe
   a_r11_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11: the strobe lasts a single cycle
   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5 R6: a reported hit is aligned and outside the header
   a_r5_hit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (cap_ofs[ALIGN_BITS-1:0] == '0 && cap_ofs >= FLOOR));

   // R11: a miss reports a zero offset
   a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (cap_ofs == '0));

   // R10: reads happen only during a walk
   a_r10_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   // R11: results are stable between strobes
   a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(fin)) |-> ($stable(found) && $stable(cap_ofs)));

endmodule

// File: tb/cap_walker_tb.sv
module cap_walker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_id = '0;
   logic       busy, done, found;
   logic [7:0] cap_ofs;
   logic       rd_req;
   logic [7:0] rd_addr;
   logic       rd_valid = 1'b0;
   logic [7:0] rd_data = '0;

   always #5 clk = ~clk;

   cap_walker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .busy(busy), .done(done), .found(found), .cap_ofs(cap_ofs),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   logic [7:0] mem [256];
   logic [7:0] alog [128];
   int lat = 1;
   int lat_cnt = 0;
   int rdcnt = 0;
   int checks = 0;
   int failures = 0;

   // configuration space model: answers after lat cycles of request
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid = 1'b0;
         lat_cnt  = 0;
      end else if (rd_valid) begin
         rd_valid = 1'b0;
         lat_cnt  = 0;
      end else if (rd_req) begin
         if (lat_cnt + 1 >= lat) begin
            rd_valid = 1'b1;
            rd_data  = mem[rd_addr];
            if (rdcnt < 128) alog[rdcnt] = rd_addr;
            rdcnt++;
            lat_cnt = 0;
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'h06] = 8'h10;
   endtask

   task automatic node(input int a, input int id, input int nxt);
      mem[a]     = 8'(id);
      mem[a + 1] = 8'(nxt);
   endtask

   task automatic base_image();
      clear_mem();
      mem[8'h34] = 8'h43;
      node('h40, 'h01, 'h52);
      node('h50, 'h05, 'h60);
      node('h60, 'h10, 'h70);
      node('h70, 'h11, 'h00);
   endtask

   task automatic walk(input logic [7:0] id, output logic f, output logic [7:0] o,
                       output int rd);
      int cyc;
      @(negedge clk);
      rdcnt     = 0;
      req_valid = 1'b1;
      req_id    = id;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 busy after accept", busy, 1);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      check("R11 done seen", done, 1);
      f  = found;
      o  = cap_ofs;
      rd = rdcnt;
   endtask

   // {id, found, ofs, reads}
   localparam logic [24:0] VEC [0:4] = '{
      {8'h01, 1'b1, 8'h40, 8'd3},
      {8'h05, 1'b1, 8'h50, 8'd5},
      {8'h10, 1'b1, 8'h60, 8'd7},
      {8'h11, 1'b1, 8'h70, 8'd9},
      {8'h22, 1'b0, 8'h00, 8'd10}
   };

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic f;
      logic [7:0] o;
      int rd;
      base_image();
      repeat (3) @(negedge clk);
      check("R1 busy in reset", busy, 0);
      check("R1 done in reset", done, 0);
      check("R1 rd_req in reset", rd_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", busy, 0);
      check("R1 rd_req after reset", rd_req, 0);

      // table sweep at two latencies
      for (int l = 1; l <= 4; l += 3) begin
         lat = l;
         for (int v = 0; v < 5; v++) begin
            walk(VEC[v][24:17], f, o, rd);
            check("R5 R8 found", f, VEC[v][16]);
            check("R5 R11 offset", o, VEC[v][15:8]);
            check("R8 R6 read count", rd, VEC[v][7:0]);
            @(negedge clk);
            check("R11 done one cycle", done, 0);
         end
      end

      // read order: status, head, aligned id, id+1
      lat = 2;
      walk(8'h05, f, o, rd);
      check("R3 first read at status", alog[0], 'h06);
      check("R4 second read at head", alog[1], 'h34);
      check("R5 id read aligned", alog[2], 'h40);
      check("R8 link read at id+1", alog[3], 'h41);
      check("R5 next node aligned", alog[4], 'h50);

      // R2: request while busy is ignored
      lat = 3;
      @(negedge clk);
      rdcnt = 0; req_valid = 1'b1; req_id = 8'h11;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk); req_valid = 1'b1; req_id = 8'h01;
      @(negedge clk); req_valid = 1'b0;
      while (!done) @(negedge clk);
      check("R2 ignored request keeps offset", cap_ofs, 'h70);
      check("R2 ignored request keeps reads", rdcnt, 9);
      repeat (4) @(negedge clk);
      check("R2 no extra walk", busy, 0);
      check("R2 no extra reads", rdcnt, 9);

      // R3: capability bit clear
      lat = 1;
      mem[8'h06] = 8'hEF;
      walk(8'h01, f, o, rd);
      check("R3 status clear not found", f, 0);
      check("R3 status clear one read", rd, 1);
      check("R11 miss offset zero", o, 0);

      // R6: head pointer just under the floor
      base_image();
      mem[8'h34] = 8'h3F;
      walk(8'h01, f, o, rd);
      check("R6 low head not found", f, 0);
      check("R6 low head reads", rd, 2);

      // R7: terminator id
      base_image();
      mem[8'h50] = 8'hFF;
      walk(8'h10, f, o, rd);
      check("R7 terminator not found", f, 0);
      check("R7 terminator reads", rd, 5);
      walk(8'hFF, f, o, rd);
      check("R7 target FF never hits", f, 0);

      // R9: self loop stopped by hop budget
      base_image();
      node('h40, 'h01, 'h40);
      walk(8'h99, f, o, rd);
      check("R9 loop not found", f, 0);
      check("R9 loop read count", rd, 98);

      // R9: hit on the 48th node is still reported
      clear_mem();
      mem[8'h34] = 8'h40;
      for (int k = 0; k < 48; k++)
         node('h40 + 4 * k, k + 1, (k == 47) ? 0 : 'h44 + 4 * k);
      walk(8'd48, f, o, rd);
      check("R9 last budget node found", f, 1);
      check("R9 last budget node offset", o, 'hFC);
      check("R9 last budget node reads", rd, 97);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule